// File: doc/BRIEF.md
# USB PHY Power-Up and Power-Down Sequencer

This block is a hardware sequencer that walks a dual-speed USB PHY wrapper through its power-up programming and, on request, through a leakage-reducing power-down. It does this by issuing register transactions on a simple internal bus. A power-up request latches two things: the speed mode (high-speed or super-speed) and a 3-bit reference-clock frequency code. The sequencer then runs a fixed ordered list of full-word writes and read-modify-write updates. That list ends with a timed port-reset pulse on the clock/reset register. A power-down request runs a shorter list.

The bus has single-cycle strobes. A read strobe in one cycle returns its data on `bus_rdata` in the next cycle, and that next cycle is always the matching write strobe. Each finished sequence raises `done` for exactly one cycle. Requests are only taken while the sequencer is idle.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset, and while idle, `bus_req` and `done` are low.
- R2: A power-up starts, in this order, with these writes: 0 to 0x14, 0 to 0x34, and 0x0800_0040 to 0x04 (bit 27 set, bits 6:1 = 0x20). Then read-modify-write clears bit 31 of 0x1C, and read-modify-write sets bit 2 of 0x30.
- R3: In high-speed mode (`hs_mode`=1), the next steps are, in order:
  - bits 30:26 of 0x1C become 0x9;
  - bits 4:0 of 0x20 become 0x1C;
  - 0x40 is written to 0x08;
  - bit 2 of 0x28 is cleared.
- R4: In super-speed mode (`hs_mode`=0), the next steps are, in order: bits 4:0 of 0x20 become 0x1C, then bit 3 of 0x28 is cleared.
- R5: Register 0x10 is then read-modify-written with bits 3:2 = 3. In high-speed mode, bits 7:5 also take the frequency code.
- R6: In super-speed mode, bits 17:11 and bits 30:23 of 0x10 follow the frequency code. Code 7 gives 0x32 and 0x00, code 5 gives 0x68 and 0x88, code 4 gives 0x7D and 0x00, and code 3 gives 0x02 and 0x88. Any other code leaves both fields unchanged.
- R7: The same 0x10 write sets bits 0, 1, 4, 19 and 20. At least WAIT_CYCLES (CLK_MHZ × RST_US) and at most WAIT_CYCLES+8 cycles later, 0x10 is written again with only bit 1 changed to 0. This ends the power-up writes.
- R8: A power-down (`exit_req`) writes 0x43 to 0x08, then clears bits 0, 19 and 20 of 0x10, then sets bits 3:2 of 0x28. All other bits are preserved.
- R9: `done` is a one-cycle pulse after the last write of a sequence. Requests made while a sequence runs are ignored. If both requests arrive together, power-up wins.
- R10: Every read strobe is followed in the next cycle by a write strobe to the same address. Bits not named in a step keep the value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start power-up sequence (sampled when idle) |
| exit_req | input | 1 | Start power-down sequence (sampled when idle) |
| hs_mode | input | 1 | 1 = high-speed, 0 = super-speed, latched with the request |
| fsel | input | 3 | Reference-clock frequency code, latched with the request |
| bus_req | output | 1 | Bus strobe |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Byte address of the register |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after a read strobe |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A wrong step counter or mode latch shows up at the first write after the divergence. That write carries the wrong address or data, or is missing or extra, so each observed write is compared against a precomputed expected list on the cycle it appears. A wrong merge of read data shows up as flipped bits in a background memory seeded with a distinct pattern per register. Errors in the wait counter show only at the port-reset release, so the gap between those two 0x10 writes is measured in cycles.

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq #(
  parameter int CLK_MHZ = 100,
  parameter int RST_US  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  input  logic        exit_req,
  input  logic        hs_mode,
  input  logic [2:0]  fsel,
  output logic        bus_req,
  output logic        bus_we,
  output logic [7:0]  bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  output logic        done
);
  localparam int WAIT_CYCLES = CLK_MHZ * RST_US;
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] CR_ON = 32'h0018_0013;

  typedef enum logic [2:0] {S_IDLE, S_DISP, S_RD, S_WR, S_WAIT} st_t;
  typedef enum logic [2:0] {K_WR, K_RMW, K_WAIT, K_SKIP, K_END} kind_t;

  st_t st;
  kind_t kind;
  logic          is_exit, mode_hs;
  logic [2:0]    fs;
  logic [3:0]    step;
  logic [CW-1:0] cnt;
  logic [31:0]   hold, clr, set;
  logic [31:0]   ss_set;
  logic          ss_known;

  always_comb begin
    ss_known = 1'b1;
    case (fs)
      3'd7:    ss_set = 32'h0001_9000;
      3'd5:    ss_set = 32'h4403_4000;
      3'd4:    ss_set = 32'h0003_E800;
      3'd3:    ss_set = 32'h4400_1000;
      default: begin ss_set = 32'h0; ss_known = 1'b0; end
    endcase
  end

  always_comb begin
    kind = K_END; bus_addr = 8'h00; clr = ONES; set = 32'h0;
    if (is_exit) begin
      case (step)
        4'd0: begin kind = K_WR;  bus_addr = 8'h08; set = 32'h43; end
        4'd1: begin kind = K_RMW; bus_addr = 8'h10; clr = 32'h0018_0001; end
        4'd2: begin kind = K_RMW; bus_addr = 8'h28; clr = 32'h0; set = 32'hC; end
        default: kind = K_END;
      endcase
    end else begin
      case (step)
        4'd0: begin kind = K_WR;  bus_addr = 8'h14; end
        4'd1: begin kind = K_WR;  bus_addr = 8'h34; end
        4'd2: begin kind = K_WR;  bus_addr = 8'h04; set = 32'h0800_0040; end
        4'd3: begin kind = K_RMW; bus_addr = 8'h1C; clr = 32'h8000_0000; end
        4'd4: begin kind = K_RMW; bus_addr = 8'h30; clr = 32'h0; set = 32'h4; end
        4'd5: if (mode_hs) begin
                kind = K_RMW; bus_addr = 8'h1C; clr = 32'h7C00_0000; set = 32'h2400_0000;
              end else begin
                kind = K_RMW; bus_addr = 8'h20; clr = 32'h1F; set = 32'h1C;
              end
        4'd6: if (mode_hs) begin
                kind = K_RMW; bus_addr = 8'h20; clr = 32'h1F; set = 32'h1C;
              end else begin
                kind = K_RMW; bus_addr = 8'h28; clr = 32'h8;
              end
        4'd7: if (mode_hs) begin kind = K_WR; bus_addr = 8'h08; set = 32'h40; end
              else kind = K_SKIP;
        4'd8: if (mode_hs) begin kind = K_RMW; bus_addr = 8'h28; clr = 32'h4; end
              else kind = K_SKIP;
        4'd9: begin
                kind = K_RMW; bus_addr = 8'h10;
                if (mode_hs) begin
                  clr = 32'hC | CR_ON | 32'hE0;
                  set = 32'hC | CR_ON | {24'h0, fs, 5'h0};
                end else begin
                  clr = 32'hC | CR_ON | (ss_known ? 32'h7F83_F800 : 32'h0);
                  set = 32'hC | CR_ON | ss_set;
                end
              end
        4'd10: kind = K_WAIT;
        4'd11: begin kind = K_WR; bus_addr = 8'h10; set = hold & ~32'h2; end
        default: kind = K_END;
      endcase
    end
  end

  assign bus_req   = (st == S_RD) || (st == S_WR);
  assign bus_we    = (st == S_WR);
  assign bus_wdata = (bus_rdata & ~clr) | set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; cnt <= '0; hold <= '0; done <= 1'b0;
      is_exit <= 1'b0; mode_hs <= 1'b0; fs <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (init_req || exit_req) begin
          is_exit <= !init_req; mode_hs <= hs_mode; fs <= fsel;
          step <= '0; st <= S_DISP;
        end
        S_DISP: case (kind)
          K_WR:   st <= S_WR;
          K_RMW:  st <= S_RD;
          K_WAIT: begin cnt <= CW'(WAIT_CYCLES - 1); st <= S_WAIT; end
          K_SKIP: step <= step + 4'd1;
          default: begin done <= 1'b1; st <= S_IDLE; end
        endcase
        S_RD: st <= S_WR;
        S_WR: begin hold <= bus_wdata; step <= step + 4'd1; st <= S_DISP; end
        S_WAIT: if (cnt == '0) begin step <= step + 4'd1; st <= S_DISP; end
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic        prst_armed;
  logic [31:0] prst_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prst_armed <= 1'b0; prst_cnt <= '0;
    end else if (bus_req && bus_we && bus_addr == 8'h10) begin
      prst_armed <= bus_wdata[1]; prst_cnt <= 32'd1;
    end else if (prst_cnt != ONES) begin
      prst_cnt <= prst_cnt + 32'd1;
    end
  end

  // R7
  prst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == 8'h10 && !bus_wdata[1] && prst_armed)
      |-> (prst_cnt >= 32'(WAIT_CYCLES)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> (bus_req && bus_we && bus_addr == $past(bus_addr)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !bus_req);
  // R2
  link_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == 8'h04) |-> (bus_wdata == 32'h0800_0040));
endmodule

// File: tb/usbphy_pwr_seq_tb.sv
module usbphy_pwr_seq_tb_top;
  localparam int W = 1000;
  logic clk = 1'b0, rst_n = 1'b0;
  logic init_req = 0, exit_req = 0, hs_mode = 0;
  logic [2:0] fsel = 0;
  logic bus_req, bus_we, done;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0, errors = 0, cyc = 0, ndone = 0, t_set = 0;
  bit prst_seen = 0, wd_fail = 0;
  logic [31:0] mem [64];
  logic [31:0] mm  [64];
  logic [7:0]  qa [$];
  logic [31:0] qd [$];
  string       qt [$];

  always #5 clk = ~clk;

  usbphy_pwr_seq #(.CLK_MHZ(100), .RST_US(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .exit_req(exit_req),
    .hs_mode(hs_mode), .fsel(fsel), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done));

  function automatic logic [31:0] pat(int i);
    return 32'hA5C3_5A3C ^ (32'(i) * 32'h0101_0107);
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = pat(i); mm[i] = pat(i); end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_req && !bus_we) bus_rdata <= mem[bus_addr[7:2]];
    if (bus_req && bus_we) mem[bus_addr[7:2]] <= bus_wdata;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) ndone++;
      if (bus_req && bus_we) begin
        if (qa.size() == 0) chk(0, "R9 unexpected write", {24'h0, bus_addr}, 32'h0);
        else begin
          chk(bus_addr == qa[0] && bus_wdata == qd[0], qt[0],
              {bus_addr, bus_wdata[23:0]}, {qa[0], qd[0][23:0]});
          if (bus_wdata != qd[0]) chk(0, qt[0], bus_wdata, qd[0]);
          void'(qa.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
        end
        if (bus_addr == 8'h10 && bus_wdata[1]) begin prst_seen = 1; t_set = cyc; end
        else if (bus_addr == 8'h10 && prst_seen) begin
          prst_seen = 0;
          chk((cyc - t_set) >= W && (cyc - t_set) <= W + 8, "R7 reset width",
              32'(cyc - t_set), 32'(W));
        end
      end
    end
  end

  task automatic ew(logic [7:0] a, logic [31:0] d, string t);
    qa.push_back(a); qd.push_back(d); qt.push_back(t); mm[a[7:2]] = d;
  endtask
  task automatic er(logic [7:0] a, logic [31:0] c, logic [31:0] s, string t);
    ew(a, (mm[a[7:2]] & ~c) | s, t);
  endtask

  task automatic exp_init(bit hs, logic [2:0] f);
    logic [31:0] v;
    ew(8'h14, 0, "R2 0x14"); ew(8'h34, 0, "R2 0x34");
    ew(8'h04, 32'h0800_0040, "R2 0x04");
    er(8'h1C, 32'h8000_0000, 0, "R2 0x1C"); er(8'h30, 0, 32'h4, "R2 0x30");
    if (hs) begin
      er(8'h1C, 32'h7C00_0000, 32'h2400_0000, "R3 loss");
      er(8'h20, 32'h1F, 32'h1C, "R3 deemph");
      ew(8'h08, 32'h40, "R3 0x08");
      er(8'h28, 32'h4, 0, "R3 0x28");
    end else begin
      er(8'h20, 32'h1F, 32'h1C, "R4 deemph");
      er(8'h28, 32'h8, 0, "R4 0x28");
    end
    v = mm[4] | 32'hC;
    if (hs) v = (v & ~32'hE0) | (32'(f) << 5);
    else begin
      case (f)
        3'd7: v = (v & ~32'h7F83_F800) | (32'h32 << 11);
        3'd5: v = (v & ~32'h7F83_F800) | (32'h68 << 11) | (32'h88 << 23);
        3'd4: v = (v & ~32'h7F83_F800) | (32'h7D << 11);
        3'd3: v = (v & ~32'h7F83_F800) | (32'h02 << 11) | (32'h88 << 23);
        default: ;
      endcase
    end
    v = v | (1 << 0) | (1 << 1) | (1 << 4) | (1 << 19) | (1 << 20);
    ew(8'h10, v, hs ? "R5 clkrst hs" : "R6 clkrst ss");
    ew(8'h10, v & ~32'h2, "R7 release");
  endtask

  task automatic exp_exit();
    ew(8'h08, 32'h43, "R8 0x08");
    er(8'h10, 32'h0018_0001, 0, "R8 0x10");
    er(8'h28, 0, 32'hC, "R8 0x28");
  endtask

  task automatic finish_run(string tag);
    int n = 0;
    while (ndone == 0 && n < 5000) begin @(negedge clk); n++; end
    repeat (20) @(negedge clk);
    chk(ndone == 1, {tag, " done count"}, 32'(ndone), 1);
    chk(qa.size() == 0, {tag, " writes missing"}, 32'(qa.size()), 0);
    chk(!done && !bus_req, "R1 idle after run", {31'h0, bus_req}, 0);
    ndone = 0;
  endtask

  task automatic do_init(bit hs, logic [2:0] f, string tag);
    exp_init(hs, f);
    init_req = 1; hs_mode = hs; fsel = f;
    @(negedge clk); init_req = 0;
    finish_run(tag);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!bus_req && !done, "R1 reset state", {31'h0, bus_req}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(!bus_req && !done, "R1 idle", {31'h0, done}, 0);
        do_init(1, 3'd5, "R3");
        do_init(0, 3'd7, "R6");
        do_init(0, 3'd5, "R6");
        do_init(0, 3'd4, "R6");
        do_init(0, 3'd3, "R6");
        do_init(0, 3'd2, "R6");
        do_init(1, 3'd1, "R5");
        exp_exit();
        exit_req = 1; @(negedge clk); exit_req = 0;
        finish_run("R8");
        exp_init(0, 3'd5);
        init_req = 1; hs_mode = 0; fsel = 3'd5;
        @(negedge clk); init_req = 0;
        repeat (8) @(negedge clk);
        exit_req = 1; init_req = 1; hs_mode = 1; fsel = 3'd1;
        @(negedge clk); exit_req = 0; init_req = 0;
        repeat (30) @(negedge clk);
        exit_req = 1; @(negedge clk); exit_req = 0;
        finish_run("R9 ignore");
        exp_init(1, 3'd4);
        init_req = 1; exit_req = 1; hs_mode = 1; fsel = 3'd4;
        @(negedge clk); init_req = 0; exit_req = 0;
        finish_run("R9 priority");
        for (int i = 0; i < 64; i++)
          chk(mem[i] == mm[i], "R10 preserved bits", mem[i], mm[i]);
      end
      begin
        repeat (150000) @(negedge clk);
        wd_fail = 1;
      end
    join_any
    if (wd_fail) chk(0, "R9 watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule